// File: doc/BRIEF.md
# Error-Correcting SRAM Controller with Sub-Word Merge

The block connects a 64-bit request/response slave port to a synchronous SRAM array built as two 39-bit lanes. Each lane holds one 32-bit data word and 7 check bits. The check bits come from a single-error-correcting, double-error-detecting code. That code covers both the data and the word address of the location. The address is not stored. It is mixed into the syndrome. A word that is read back from the wrong location therefore fails its check.

Reads and full-word writes go through at the bus rate. A byte or halfword write reads the containing word, corrects it, merges in the new bytes, re-encodes the result and writes it back, and the bus stalls during this. Detected errors raise one-cycle event pulses that carry the failing word address. The first event is held in a status record until a clear pulse arrives. An injection control corrupts chosen bits of the next array write, so that the correction and detection paths can be exercised.

Top module: `ecc_sram_ctrl`

## Requirements
- R1: A read is accepted without stall, and `rsp_valid` is high in the cycle after acceptance with the corrected data. Lane 0 holds the word at byte address bit 2 = 0 and returns on `rsp_rdata[31:0]`. Lane 1 returns on `rsp_rdata[63:32]`.
- R2: A 32-bit write (`bus_size`=2) is accepted without stall. It writes only its own lane (`mem_we` bit = byte address bit 2) in the acceptance cycle and responds in the next cycle.
- R3: A 64-bit write (`bus_size`=3) writes both lanes in the acceptance cycle (`mem_we`=2'b11). Each lane is encoded with its own word address, and the write adds no stall.
- R4: A byte write (`bus_size`=0) or halfword write (`bus_size`=1) holds `bus_ready` low for exactly 3 cycles and responds 4 cycles after acceptance. The stored word then holds the old bytes with the addressed bytes replaced. Bytes are taken from their own positions in `bus_wdata`.
- R5: A single flipped data or check bit in a checked lane is corrected in the returned data. It raises `ev_sb` in the response cycle and leaves `rsp_err` low.
- R6: Two flipped bits in a checked lane raise `ev_mb` and `rsp_err`.
- R7: A lane image written for one word address and read at an address that differs in one word-address bit is reported as uncorrectable.
- R8: A sub-word write whose read phase finds an uncorrectable error does not write the array and responds with `rsp_err`. A correctable error found in that phase is fixed before the merge.
- R9: A pulse on `inj_arm` stores `inj_mask`. The mask is XORed into the 39-bit image of each lane in the next array write only. Mask bits 31:0 are data bits and bits 38:32 are check bits.
- R10: The first event captures `st_valid`, `st_mb`, `st_addr` and a nonzero `st_syn`. These values hold through later events until `st_clr` clears them.
- R11: Only the lanes that an access covers are checked. An error in the other lane of the row raises no event and no `rsp_err`.
- R12: `ev_addr` is the 32-bit word address of the failing word. Lane 0 has priority when both lanes of a 64-bit read fail.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Request present |
| bus_ready | output | 1 | Request can be accepted |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_size | input | 2 | 0 byte, 1 halfword, 2 word, 3 doubleword |
| bus_addr | input | AW | Byte address, aligned to the size |
| bus_wdata | input | 64 | Write data in byte lanes |
| rsp_valid | output | 1 | Response this cycle |
| rsp_rdata | output | 64 | Corrected read data |
| rsp_err | output | 1 | Error response |
| inj_arm | input | 1 | Load injection mask for the next array write |
| inj_mask | input | 39 | Bits to flip in each written lane image |
| ev_sb | output | 1 | Corrected-error event pulse |
| ev_mb | output | 1 | Uncorrectable-error event pulse |
| ev_addr | output | AW-2 | Word address of the event |
| st_valid | output | 1 | Status record holds an event |
| st_mb | output | 1 | Held event was uncorrectable |
| st_addr | output | AW-2 | Held word address |
| st_syn | output | 7 | Held syndrome |
| st_clr | input | 1 | Clear the status record |
| mem_addr | output | AW-3 | Array row address |
| mem_we | output | 2 | Per-lane write enable |
| mem_wdata | output | 78 | Two encoded lane images |
| mem_rdata | input | 78 | Array read data, one cycle after the address |

## Verification
If the merge register or the held row goes wrong during a sub-word write, the damage stays hidden until the word is read back. The bench therefore reads back every sub-word write right after it. A wrong state sequence shows at once as a stall count other than 3 or a response outside cycle 4. Injection and address-mixing faults appear in the response cycle of the next read, as an event flag that is missing or wrong. The bench also inspects the array image directly, so a write-back that should have been suppressed is seen before any further traffic.

// File: rtl/ecc_sram_ctrl.sv
module ecc_sram_ctrl #(
  parameter int AW = 12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_valid,
  output logic            bus_ready,
  input  logic            bus_write,
  input  logic [1:0]      bus_size,
  input  logic [AW-1:0]   bus_addr,
  input  logic [63:0]     bus_wdata,
  output logic            rsp_valid,
  output logic [63:0]     rsp_rdata,
  output logic            rsp_err,
  input  logic            inj_arm,
  input  logic [38:0]     inj_mask,
  output logic            ev_sb,
  output logic            ev_mb,
  output logic [AW-3:0]   ev_addr,
  output logic            st_valid,
  output logic            st_mb,
  output logic [AW-3:0]   st_addr,
  output logic [6:0]      st_syn,
  input  logic            st_clr,
  output logic [AW-4:0]   mem_addr,
  output logic [1:0]      mem_we,
  output logic [77:0]     mem_wdata,
  input  logic [77:0]     mem_rdata
);
  localparam int WAW = AW - 2;
  localparam int RW  = AW - 3;

  function automatic logic [6:0] dcol(input int j);
    int n;
    n = 0;
    dcol = '0;
    for (int v = 1; v < 128; v++)
      if ($countones(7'(v)) == 3) begin
        if (n == j) dcol = 7'(v);
        n++;
      end
  endfunction

  function automatic logic [6:0] acol(input int j);
    int n;
    n = 0;
    acol = '0;
    for (int v = 1; v < 128; v++)
      if ($countones(7'(v)) % 2 == 0) begin
        if (n == j) acol = 7'(v);
        n++;
      end
  endfunction

  function automatic logic [6:0] cbits(input logic [31:0] d, input logic [WAW-1:0] wa);
    cbits = '0;
    for (int j = 0; j < 32; j++) if (d[j]) cbits ^= dcol(j);
    for (int j = 0; j < WAW; j++) if (wa[j]) cbits ^= acol(j);
  endfunction

  function automatic logic [31:0] fixmask(input logic [6:0] s);
    fixmask = '0;
    for (int j = 0; j < 32; j++) if (s == dcol(j)) fixmask[j] = 1'b1;
  endfunction

  typedef enum logic [1:0] {S_IDLE, S_RMW_RD, S_RMW_WR, S_RMW_END} state_t;
  state_t state;

  logic          pend_rd, pend_wr, pend_rmw, abort_r, h_lane, inj_on;
  logic [1:0]    h_chk;
  logic [3:0]    h_bm;
  logic [31:0]   h_wd, m_word;
  logic [RW-1:0] h_row;
  logic [38:0]   inj_val;

  logic [1:0][31:0] rd_d;
  logic [1:0][6:0]  syn;
  logic [1:0]       sb, mb;

  wire acc    = bus_valid && bus_ready;
  wire sub    = bus_size < 2'd2;
  wire wr_now = acc && bus_write && !sub;
  wire idle   = state == S_IDLE;
  wire chk_on = pend_rd || state == S_RMW_RD;
  wire e0     = h_chk[0] && (sb[0] || mb[0]);

  assign bus_ready = idle;

  always_comb
    for (int k = 0; k < 2; k++) begin
      logic [38:0] ln;
      logic [31:0] fx;
      ln     = mem_rdata[39*k +: 39];
      syn[k] = ln[38:32] ^ cbits(ln[31:0], {h_row, 1'(k)});
      fx     = fixmask(syn[k]);
      sb[k]  = (syn[k] != '0) && (^syn[k]) && ($countones(syn[k]) == 1 || fx != '0);
      mb[k]  = (syn[k] != '0) && !sb[k];
      rd_d[k] = ln[31:0] ^ (sb[k] ? fx : 32'h0);
    end

  assign rsp_valid = pend_rd || pend_wr || pend_rmw;
  assign rsp_rdata = {rd_d[1], rd_d[0]};
  assign rsp_err   = (pend_rd && |(h_chk & mb)) || (pend_rmw && abort_r);
  assign ev_sb     = chk_on && |(h_chk & sb);
  assign ev_mb     = chk_on && |(h_chk & mb);
  assign ev_addr   = {h_row, !e0};

  wire [3:0] bm_in = bus_size == 2'd0 ? 4'b0001 << bus_addr[1:0] :
                     bus_size == 2'd1 ? 4'b0011 << {bus_addr[1], 1'b0} : 4'b1111;
  wire [31:0] bmx = {{8{h_bm[3]}}, {8{h_bm[2]}}, {8{h_bm[1]}}, {8{h_bm[0]}}};

  assign mem_addr = idle ? bus_addr[AW-1:3] : h_row;
  assign mem_we   = (state == S_RMW_WR && !abort_r) ? (h_lane ? 2'b10 : 2'b01) :
                    wr_now ? (bus_size == 2'd3 ? 2'b11 : (bus_addr[2] ? 2'b10 : 2'b01)) : 2'b00;

  wire [31:0] lo_d  = idle ? bus_wdata[31:0]  : m_word;
  wire [31:0] hi_d  = idle ? bus_wdata[63:32] : m_word;
  wire [38:0] inj_v = inj_on ? inj_val : 39'h0;
  assign mem_wdata = {{cbits(hi_d, {mem_addr, 1'b1}), hi_d} ^ inj_v,
                      {cbits(lo_d, {mem_addr, 1'b0}), lo_d} ^ inj_v};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE;
      {pend_rd, pend_wr, pend_rmw, abort_r, h_lane, inj_on} <= '0;
      h_chk <= '0; h_bm <= '0; h_wd <= '0; m_word <= '0; h_row <= '0; inj_val <= '0;
      st_valid <= 1'b0; st_mb <= 1'b0; st_addr <= '0; st_syn <= '0;
    end else begin
      pend_rd  <= acc && !bus_write;
      pend_wr  <= wr_now;
      pend_rmw <= state == S_RMW_END;
      if (acc) begin
        h_row  <= bus_addr[AW-1:3];
        h_lane <= bus_addr[2];
        h_chk  <= (!bus_write && bus_size == 2'd3) ? 2'b11 : (bus_addr[2] ? 2'b10 : 2'b01);
        h_bm   <= bm_in;
        h_wd   <= bus_addr[2] ? bus_wdata[63:32] : bus_wdata[31:0];
      end
      case (state)
        S_IDLE:    if (acc && bus_write && sub) state <= S_RMW_RD;
        S_RMW_RD: begin
          m_word  <= (rd_d[h_lane] & ~bmx) | (h_wd & bmx);
          abort_r <= mb[h_lane];
          state   <= S_RMW_WR;
        end
        S_RMW_WR:  state <= S_RMW_END;
        default:   state <= S_IDLE;
      endcase
      if (inj_arm) begin
        inj_on <= 1'b1; inj_val <= inj_mask;
      end else if (mem_we != 2'b00) inj_on <= 1'b0;
      if ((ev_sb || ev_mb) && (!st_valid || st_clr)) begin
        st_valid <= 1'b1; st_mb <= ev_mb; st_addr <= ev_addr;
        st_syn   <= e0 ? syn[0] : syn[1];
      end else if (st_clr) st_valid <= 1'b0;
    end
  end

  assert_read_rsp_R1: assert property (@(posedge clk) disable iff (!rst_n)
    acc && !bus_write |=> rsp_valid);
  assert_dword_lanes_R3: assert property (@(posedge clk) disable iff (!rst_n)
    acc && bus_write && bus_size == 2'd3 |-> mem_we == 2'b11 && bus_ready);
  assert_sub_stall_R4: assert property (@(posedge clk) disable iff (!rst_n)
    acc && bus_write && sub |=> !bus_ready && !rsp_valid);
  assert_abort_nowrite_R8: assert property (@(posedge clk) disable iff (!rst_n)
    state == S_RMW_RD && ev_mb |=> mem_we == 2'b00);
  assert_status_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    st_valid && !st_clr |=> st_valid && $stable(st_addr) && $stable(st_mb));
endmodule

// File: tb/ecc_sram_ctrl_bench.sv
module ecc_sram_ctrl_bench;
  logic clk = 0, rst_n = 0;
  always #2.5 clk = ~clk;

  logic bus_valid = 0, bus_write = 0, inj_arm = 0, st_clr = 0;
  logic [1:0] bus_size = 0;
  logic [11:0] bus_addr = 0;
  logic [63:0] bus_wdata = 0;
  logic [38:0] inj_mask = 0;
  logic bus_ready, rsp_valid, rsp_err, ev_sb, ev_mb, st_valid, st_mb;
  logic [63:0] rsp_rdata;
  logic [9:0] ev_addr, st_addr;
  logic [6:0] st_syn;
  logic [8:0] mem_addr;
  logic [1:0] mem_we;
  logic [77:0] mem_wdata, mem_rdata;

  ecc_sram_ctrl #(.AW(12)) u_ecc_sram_ctrl (.*);

  logic [77:0] mem [0:511];
  logic bd_copy = 0;
  logic [8:0] bd_src = 0, bd_dst = 0;
  always @(posedge clk) begin
    if (!rst_n) for (int i = 0; i < 512; i++) mem[i] <= '0;
    else begin
      if (bd_copy) mem[bd_dst] <= mem[bd_src];
      if (mem_we[0]) mem[mem_addr][38:0]  <= mem_wdata[38:0];
      if (mem_we[1]) mem[mem_addr][77:39] <= mem_wdata[77:39];
    end
    mem_rdata <= mem[mem_addr];
  end

  int checks = 0, errors = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  logic [63:0] r_data;
  logic r_err, r_sb, r_mb;
  logic [1:0] r_we0;
  logic [9:0] r_evaddr;
  int r_lat, r_stall;

  task automatic xfer(input logic w, input logic [1:0] sz, input logic [11:0] a, input logic [63:0] d);
    @(negedge clk);
    bus_valid = 1; bus_write = w; bus_size = sz; bus_addr = a; bus_wdata = d;
    #1 r_we0 = mem_we;
    @(posedge clk); #1 bus_valid = 0;
    r_lat = 0; r_stall = 0; r_sb = 0; r_mb = 0; r_evaddr = '0;
    do begin
      @(negedge clk);
      r_lat++;
      if (!bus_ready) r_stall++;
      if (ev_sb) r_sb = 1;
      if (ev_mb) r_mb = 1;
      if ((ev_sb || ev_mb) && r_evaddr == '0) r_evaddr = ev_addr;
    end while (!rsp_valid && r_lat < 10);
    r_data = rsp_rdata; r_err = rsp_err;
  endtask

  task automatic arm(input logic [38:0] m);
    @(negedge clk); inj_arm = 1; inj_mask = m;
    @(posedge clk); #1 inj_arm = 0;
  endtask

  task automatic pulse_clr();
    @(negedge clk); st_clr = 1;
    @(posedge clk); #1 st_clr = 0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(bus_ready && !rsp_valid && !st_valid && !ev_sb && !ev_mb && mem_we == 0, "reset",
        {bus_ready, rsp_valid, st_valid, ev_sb, ev_mb}, 64'h10);
  endtask

  task automatic t_word();
    xfer(1, 2, 12'h010, 64'h0_11223344);
    chk(r_we0 == 2'b01 && r_lat == 1 && r_stall == 0, "R2 lane0 write", {r_we0, 8'(r_lat)}, {2'b01, 8'd1});
    xfer(1, 2, 12'h014, 64'hAABBCCDD_00000000);
    chk(r_we0 == 2'b10 && r_lat == 1, "R2 lane1 write", r_we0, 2'b10);
    xfer(0, 3, 12'h010, 0);
    chk(r_data == 64'hAABBCCDD_11223344 && r_lat == 1 && r_stall == 0 && !r_err,
        "R1 read64", r_data, 64'hAABBCCDD_11223344);
  endtask

  task automatic t_dword();
    xfer(1, 3, 12'h020, 64'h01234567_89ABCDEF);
    chk(r_we0 == 2'b11 && r_lat == 1 && r_stall == 0, "R3 dword write", {r_we0, 8'(r_stall)}, {2'b11, 8'd0});
    xfer(0, 2, 12'h024, 0);
    chk(r_data[63:32] == 32'h01234567 && !r_sb && !r_mb, "R3 lane1 readback", r_data[63:32], 32'h01234567);
  endtask

  task automatic t_subword();
    xfer(1, 0, 12'h021, 64'h0000_5A00);
    chk(r_stall == 3 && r_lat == 4 && !r_err, "R4 byte stall", {8'(r_stall), 8'(r_lat)}, {8'd3, 8'd4});
    xfer(1, 1, 12'h026, 64'hBEEF0000_00000000);
    chk(r_stall == 3 && r_lat == 4, "R4 half stall", {8'(r_stall), 8'(r_lat)}, {8'd3, 8'd4});
    xfer(0, 3, 12'h020, 0);
    chk(r_data == 64'hBEEF4567_89AB5AEF && !r_sb && !r_mb, "R4 merged", r_data, 64'hBEEF4567_89AB5AEF);
  endtask

  task automatic t_inject_single();
    arm(39'h20);
    xfer(1, 2, 12'h030, 64'hCAFEF00D);
    chk(mem[6][31:0] == (32'hCAFEF00D ^ 32'h20), "R9 flipped bit stored", mem[6][31:0], 32'hCAFEF00D ^ 32'h20);
    xfer(1, 2, 12'h034, 64'h76543210_00000000);
    chk(mem[6][70:39] == 32'h76543210, "R9 single use", mem[6][70:39], 32'h76543210);
    xfer(0, 2, 12'h030, 0);
    chk(r_data[31:0] == 32'hCAFEF00D && r_sb && !r_mb && !r_err, "R5 data bit corrected",
        {r_sb, r_mb, r_err, r_data[31:0]}, {3'b100, 32'hCAFEF00D});
    chk(r_evaddr == 10'h00C, "R12 event address", r_evaddr, 10'h00C);
    @(negedge clk);
    chk(st_valid && !st_mb && st_addr == 10'h00C && st_syn != 0, "R10 capture",
        {st_valid, st_mb, st_addr}, {2'b10, 10'h00C});
  endtask

  task automatic t_check_bit();
    arm(39'h1 << 35);
    xfer(1, 2, 12'h038, 64'h12345678);
    xfer(0, 2, 12'h038, 0);
    chk(r_data[31:0] == 32'h12345678 && r_sb && !r_mb && !r_err, "R5 check bit corrected",
        {r_sb, r_mb, r_data[31:0]}, {2'b10, 32'h12345678});
    @(negedge clk);
    chk(st_valid && st_addr == 10'h00C, "R10 hold", st_addr, 10'h00C);
    pulse_clr();
    chk(!st_valid, "R10 clear", st_valid, 0);
  endtask

  task automatic t_double();
    arm(39'h3);
    xfer(1, 2, 12'h040, 64'hFFFF0000);
    xfer(0, 2, 12'h040, 0);
    chk(r_mb && !r_sb && r_err, "R6 double error", {r_sb, r_mb, r_err}, 3'b011);
    @(negedge clk);
    chk(st_valid && st_mb && st_addr == 10'h010, "R10 mb capture", {st_valid, st_mb, st_addr}, {2'b11, 10'h010});
  endtask

  task automatic t_rmw_abort();
    logic [77:0] save;
    save = mem[8];
    xfer(1, 0, 12'h041, 64'hAB00);
    chk(r_err && r_stall == 3 && r_mb, "R8 abort response", {r_err, 8'(r_stall)}, {1'b1, 8'd3});
    chk(mem[8] == save, "R8 array untouched", mem[8][63:0], save[63:0]);
  endtask

  task automatic t_addr_swap();
    xfer(1, 3, 12'h050, 64'h11112222_33334444);
    xfer(1, 3, 12'h058, 64'h55556666_77778888);
    @(negedge clk); bd_src = 9'd10; bd_dst = 9'd11; bd_copy = 1;
    @(posedge clk); #1 bd_copy = 0;
    xfer(0, 3, 12'h058, 0);
    chk(r_mb && r_err, "R7 wrong address detected", {r_mb, r_err}, 2'b11);
    xfer(0, 3, 12'h050, 0);
    chk(!r_mb && !r_sb && r_data == 64'h11112222_33334444, "R7 source row clean", r_data, 64'h11112222_33334444);
  endtask

  task automatic t_lanes();
    xfer(1, 2, 12'h060, 64'h0BADBEEF);
    arm(39'h18);
    xfer(1, 2, 12'h064, 64'h600D600D_00000000);
    xfer(0, 2, 12'h060, 0);
    chk(!r_sb && !r_mb && !r_err && r_data[31:0] == 32'h0BADBEEF, "R11 other lane ignored",
        {r_sb, r_mb, r_err}, 3'b000);
    xfer(0, 3, 12'h060, 0);
    chk(r_mb && r_err && r_evaddr == 10'h019, "R11 lane1 checked on read64", {r_mb, r_evaddr}, {1'b1, 10'h019});
    arm(39'h80);
    xfer(1, 3, 12'h068, 64'h22222222_11111111);
    xfer(0, 3, 12'h068, 0);
    chk(r_sb && !r_mb && r_evaddr == 10'h01A && r_data == 64'h22222222_11111111, "R12 lane0 priority",
        r_evaddr, 10'h01A);
  endtask

  task automatic t_rmw_fix();
    arm(39'h200);
    xfer(1, 2, 12'h070, 64'h0000FFFF);
    xfer(1, 0, 12'h073, 64'h77000000);
    chk(!r_err && r_sb && r_lat == 4, "R8 correctable during merge", {r_err, r_sb}, 2'b01);
    xfer(0, 2, 12'h070, 0);
    chk(r_data[31:0] == 32'h7700FFFF && !r_sb && !r_mb, "R4 clean write-back", r_data[31:0], 32'h7700FFFF);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    t_reset();
    t_word();
    t_dword();
    t_subword();
    t_inject_single();
    t_check_bit();
    t_double();
    t_rmw_abort();
    t_addr_swap();
    t_lanes();
    t_rmw_fix();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule